// File: doc/BRIEF.md
# Multi-Lane Integer Dot-Product Accumulator

This block is the contraction datapath of a compute slice. An instruction drives eight reduction lanes at once. Each lane multiplies two 512-bit operand vectors element by element in signed 8-bit or signed 4-bit format and reduces the products to one scalar. It then adds that scalar into its own entry of a 1024-entry accumulator array. Operand A comes either from the lane's private single-ported register bank or from a broadcast streaming vector. Operand B always comes from the streaming vector.

Register banks are loaded through a write port that addresses one bank per cycle. A bank cannot read and write in the same cycle, so an instruction that needs the banks waits while a write is in progress. The pipeline has three stages: products, reduction, then accumulate. Consecutive instructions may target the same accumulator row, because the pending sum is forwarded. A combinational read port exposes any accumulator.

Top module: `dotacc_engine`

## Requirements
- R1: After reset every accumulator reads 0 on `rdData`.
- R2: With `instrFmt`=0, each vector holds 64 signed 8-bit elements, element i at bits [8i+7:8i]. Lane l's result is the sum over i of A_l[i]*B[i].
- R3: With `instrFmt`=1, each vector holds 128 signed 4-bit elements, element i at bits [4i+3:4i]. Lane l's result is the sum over i of A_l[i]*B[i].
- R4: With `instrSrcRf`=1, A_l is bank l at `instrRfAddr`. With `instrSrcRf`=0, A_l is `streamVec`. B is always `streamVec`, sampled at issue. Lane l updates accumulator index `instrAccRow`*8 + l, so the lane number sits in the index's low 3 bits.
- R5: An update adds the lane result to the 32-bit accumulator with two's-complement wrap. When `instrClear`=1, the result replaces the old value instead.
- R6: An instruction issued at clock edge k changes `rdData` for its accumulators right after edge k+3, and not before.
- R7: Instructions issued on consecutive cycles to the same row each take effect, and none is lost.
- R8: `instrReady` is 0 exactly when `rfWrEn`=1 and `instrSrcRf`=1. A stalled instruction has no effect, while the bank write still completes. A write of `rfWrData` to bank `rfWrBank` at `rfWrAddr` is seen by later reads.
- R9: An accumulator that no issued instruction targets keeps its value, and `rdData` is `accumulator[rdIdx]` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instrValid | input | 1 | Instruction present |
| instrReady | output | 1 | Instruction accepted this cycle |
| instrSrcRf | input | 1 | 1: operand A from register banks, 0: from stream |
| instrFmt | input | 1 | 0: signed 8-bit elements, 1: signed 4-bit elements |
| instrRfAddr | input | 4 | Register bank entry for operand A |
| instrAccRow | input | 7 | Accumulator row (index bits [9:3]) |
| instrClear | input | 1 | Replace rather than add |
| streamVec | input | 512 | Broadcast streaming operand |
| rfWrEn | input | 1 | Register bank write enable |
| rfWrBank | input | 3 | Bank selected for write |
| rfWrAddr | input | 4 | Entry written |
| rfWrData | input | 512 | Data written |
| rdIdx | input | 10 | Accumulator read index |
| rdData | output | 32 | Accumulator value at `rdIdx` |

## Verification
The assertions assume that the issue strobe, the bank write enable and the read index are never X after reset, and that the issue handshake is the only thing that moves the pipeline. The stimulus drives every input at the falling edge, keeps it steady through the next rising edge, and issues only through `instrValid` qualified by `instrReady`. Before any instruction reads a bank entry, the stimulus fills every bank entry, so no operand is undefined.

// File: rtl/dotacc_pkg.sv
package dotacc_pkg;
  // strobes from control to datapath, one bit each
  typedef struct packed {
    logic captureEn; // instruction issued this cycle
    logic rfRead;    // issued instruction reads the banks
    logic srcRfS1;   // operand A source of stage-1 instruction
    logic fmtS1;     // element format of stage-1 instruction
    logic loadProd;  // stage 1 valid: load product registers
    logic loadSum;   // stage 2 valid: load sum and old value
    logic accWrite;  // stage 3 valid: write accumulators
    logic clearS3;   // stage-3 instruction replaces value
    logic fwdHit;    // stage-3 write targets stage-2 row
  } ctrlStrobes_t;
endpackage

// File: rtl/dotacc_lane.sv
module dotacc_lane #(
  parameter int VEC_W = 512,
  parameter int SUM_W = 22
) (
  input  logic                    clk,
  input  logic                    prodLoad,
  input  logic                    sumLoad,
  input  logic                    fmtInt4,
  input  logic [VEC_W-1:0]        opA,
  input  logic [VEC_W-1:0]        opB,
  output logic signed [SUM_W-1:0] sumOut
);
  localparam int BYTES  = VEC_W / 8;
  localparam int PROD_W = 16;

  logic signed [PROD_W-1:0] prodC [BYTES];
  logic signed [PROD_W-1:0] prodQ [BYTES];
  logic signed [SUM_W-1:0]  sumC;

  // per byte: one 8x8 product, or two 4x4 products added
  always_comb begin
    for (int b = 0; b < BYTES; b++) begin
      logic [7:0] aB, bB;
      logic signed [PROD_W-1:0] aLo, bLo, aHi, bHi, aW, bW;
      aB  = opA[b*8 +: 8];
      bB  = opB[b*8 +: 8];
      aW  = {{8{aB[7]}}, aB};
      bW  = {{8{bB[7]}}, bB};
      aLo = {{12{aB[3]}}, aB[3:0]};
      bLo = {{12{bB[3]}}, bB[3:0]};
      aHi = {{12{aB[7]}}, aB[7:4]};
      bHi = {{12{bB[7]}}, bB[7:4]};
      prodC[b] = fmtInt4 ? (aLo * bLo + aHi * bHi) : (aW * bW);
    end
  end

  always_ff @(posedge clk) begin
    if (prodLoad) begin
      for (int b = 0; b < BYTES; b++) prodQ[b] <= prodC[b];
    end
  end

  always_comb begin
    sumC = '0;
    for (int b = 0; b < BYTES; b++)
      sumC = sumC + {{(SUM_W-PROD_W){prodQ[b][PROD_W-1]}}, prodQ[b]};
  end

  always_ff @(posedge clk) begin
    if (sumLoad) sumOut <= sumC;
  end
endmodule

// File: rtl/dotacc_ctrl.sv
module dotacc_ctrl
  import dotacc_pkg::*;
#(
  parameter int ROW_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instrValid,
  input  logic             instrSrcRf,
  input  logic             instrFmt,
  input  logic [ROW_W-1:0] instrAccRow,
  input  logic             instrClear,
  input  logic             rfWrEn,
  output logic             instrReady,
  output ctrlStrobes_t     strobes,
  output logic [ROW_W-1:0] rowS2,
  output logic [ROW_W-1:0] rowS3
);
  logic issue;
  logic v1, v2, v3;
  logic src1, fmt1;
  logic clr1, clr2, clr3;
  logic [ROW_W-1:0] row1;

  // a bank write blocks any instruction that reads the banks
  assign instrReady = !(rfWrEn && instrSrcRf);
  assign issue      = instrValid && instrReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      src1 <= 1'b0; fmt1 <= 1'b0;
      clr1 <= 1'b0; clr2 <= 1'b0; clr3 <= 1'b0;
      row1 <= '0; rowS2 <= '0; rowS3 <= '0;
    end else begin
      v1 <= issue;
      v2 <= v1;
      v3 <= v2;
      if (issue) begin
        src1 <= instrSrcRf;
        fmt1 <= instrFmt;
        clr1 <= instrClear;
        row1 <= instrAccRow;
      end
      clr2  <= clr1;
      rowS2 <= row1;
      clr3  <= clr2;
      rowS3 <= rowS2;
    end
  end

  always_comb begin
    strobes.captureEn = issue;
    strobes.rfRead    = issue && instrSrcRf;
    strobes.srcRfS1   = src1;
    strobes.fmtS1     = fmt1;
    strobes.loadProd  = v1;
    strobes.loadSum   = v2;
    strobes.accWrite  = v3;
    strobes.clearS3   = clr3;
    strobes.fwdHit    = v3 && v2 && (rowS3 == rowS2);
  end
endmodule

// File: rtl/dotacc_datapath.sv
module dotacc_datapath
  import dotacc_pkg::*;
#(
  parameter int LANES       = 8,
  parameter int VEC_W       = 512,
  parameter int ACC_ENTRIES = 1024,
  parameter int ACC_W       = 32,
  parameter int RF_DEPTH    = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobes_t                   strobes,
  input  logic [$clog2(RF_DEPTH)-1:0]    rfAddr,
  input  logic                           rfWrEn,
  input  logic [$clog2(LANES)-1:0]       rfWrBank,
  input  logic [$clog2(RF_DEPTH)-1:0]    rfWrAddr,
  input  logic [VEC_W-1:0]               rfWrData,
  input  logic [VEC_W-1:0]               streamVec,
  input  logic [$clog2(ACC_ENTRIES/LANES)-1:0] rowS2,
  input  logic [$clog2(ACC_ENTRIES/LANES)-1:0] rowS3,
  input  logic [$clog2(ACC_ENTRIES)-1:0] rdIdx,
  output logic [ACC_W-1:0]               rdData
);
  localparam int BANK_W = $clog2(LANES);
  localparam int SUM_W  = 16 + $clog2(VEC_W / 8);

  logic [VEC_W-1:0] streamQ;
  logic [VEC_W-1:0] rdQ   [LANES];
  logic [VEC_W-1:0] opA   [LANES];
  logic signed [SUM_W-1:0] laneSum [LANES];
  logic [ACC_W-1:0] accOldQ [LANES];
  logic [ACC_W-1:0] newVal  [LANES];
  logic [ACC_W-1:0] accMem  [ACC_ENTRIES];

  always_ff @(posedge clk) begin
    if (strobes.captureEn) streamQ <= streamVec;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [BANK_W-1:0] LID = BANK_W'(l);
    logic [VEC_W-1:0] bankMem [RF_DEPTH];

    // single port: one write or one read per cycle
    always_ff @(posedge clk) begin
      if (rfWrEn && rfWrBank == LID) bankMem[rfWrAddr] <= rfWrData;
      else if (strobes.rfRead)       rdQ[l] <= bankMem[rfAddr];
    end

    assign opA[l] = strobes.srcRfS1 ? rdQ[l] : streamQ;

    dotacc_lane #(.VEC_W(VEC_W), .SUM_W(SUM_W)) lane_i (
      .clk     (clk),
      .prodLoad(strobes.loadProd),
      .sumLoad (strobes.loadSum),
      .fmtInt4 (strobes.fmtS1),
      .opA     (opA[l]),
      .opB     (streamQ),
      .sumOut  (laneSum[l])
    );

    // old value, with the stage-3 result forwarded on a row match
    always_ff @(posedge clk) begin
      if (strobes.loadSum)
        accOldQ[l] <= strobes.fwdHit ? newVal[l] : accMem[{rowS2, LID}];
    end

    always_comb begin
      logic [ACC_W-1:0] ext;
      ext = {{(ACC_W-SUM_W){laneSum[l][SUM_W-1]}}, laneSum[l]};
      newVal[l] = strobes.clearS3 ? ext : accOldQ[l] + ext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ACC_ENTRIES; i++) accMem[i] <= '0;
    end else if (strobes.accWrite) begin
      for (int l = 0; l < LANES; l++) accMem[{rowS3, BANK_W'(l)}] <= newVal[l];
    end
  end

  assign rdData = accMem[rdIdx];
endmodule

// File: rtl/dotacc_engine.sv
module dotacc_engine
  import dotacc_pkg::*;
#(
  parameter int LANES       = 8,
  parameter int VEC_W       = 512,
  parameter int ACC_ENTRIES = 1024,
  parameter int ACC_W       = 32,
  parameter int RF_DEPTH    = 16,
  localparam int ROW_W      = $clog2(ACC_ENTRIES / LANES),
  localparam int IDX_W      = $clog2(ACC_ENTRIES),
  localparam int RF_AW      = $clog2(RF_DEPTH),
  localparam int BANK_W     = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  output logic              instrReady,
  input  logic              instrSrcRf,
  input  logic              instrFmt,
  input  logic [RF_AW-1:0]  instrRfAddr,
  input  logic [ROW_W-1:0]  instrAccRow,
  input  logic              instrClear,
  input  logic [VEC_W-1:0]  streamVec,
  input  logic              rfWrEn,
  input  logic [BANK_W-1:0] rfWrBank,
  input  logic [RF_AW-1:0]  rfWrAddr,
  input  logic [VEC_W-1:0]  rfWrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [ACC_W-1:0]  rdData
);
  ctrlStrobes_t     strobes;
  logic [ROW_W-1:0] rowS2, rowS3;

  dotacc_ctrl #(.ROW_W(ROW_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .instrSrcRf (instrSrcRf),
    .instrFmt   (instrFmt),
    .instrAccRow(instrAccRow),
    .instrClear (instrClear),
    .rfWrEn     (rfWrEn),
    .instrReady (instrReady),
    .strobes    (strobes),
    .rowS2      (rowS2),
    .rowS3      (rowS3)
  );

  dotacc_datapath #(
    .LANES(LANES), .VEC_W(VEC_W), .ACC_ENTRIES(ACC_ENTRIES),
    .ACC_W(ACC_W), .RF_DEPTH(RF_DEPTH)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rfAddr   (instrRfAddr),
    .rfWrEn   (rfWrEn),
    .rfWrBank (rfWrBank),
    .rfWrAddr (rfWrAddr),
    .rfWrData (rfWrData),
    .streamVec(streamVec),
    .rowS2    (rowS2),
    .rowS3    (rowS3),
    .rdIdx    (rdIdx),
    .rdData   (rdData)
  );
endmodule

// File: rtl/dotacc_checker.sv
module dotacc_checker #(
  parameter int IDX_W = 10,
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             rfWrEn,
  input logic             rfRead,
  input logic             issue,
  input logic             accWrite,
  input logic [IDX_W-1:0] rdIdx,
  input logic [ACC_W-1:0] rdData
);
  // R8
  bank_port_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> !rfRead);

  // R6
  issue_to_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    issue |-> ##3 accWrite);

  // R6
  write_from_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    accWrite |-> $past(issue, 3));

  // R9
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accWrite |=> (!$stable(rdIdx) || $stable(rdData)));
endmodule

bind dotacc_engine dotacc_checker #(.IDX_W(IDX_W), .ACC_W(ACC_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .rfWrEn  (rfWrEn),
  .rfRead  (strobes.rfRead),
  .issue   (instrValid && instrReady),
  .accWrite(strobes.accWrite),
  .rdIdx   (rdIdx),
  .rdData  (rdData)
);

// File: tb/dotacc_engine_tb_top.sv
module dotacc_engine_tb_top;
  localparam int LANES = 8, VEC_W = 512, ACC_N = 1024, RF_D = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic instrValid = 0, instrSrcRf = 0, instrFmt = 0, instrClear = 0;
  logic [3:0] instrRfAddr = '0;
  logic [6:0] instrAccRow = '0;
  logic [VEC_W-1:0] streamVec = '0, rfWrData = '0;
  logic rfWrEn = 0;
  logic [2:0] rfWrBank = '0;
  logic [3:0] rfWrAddr = '0;
  logic [9:0] rdIdx = '0;
  logic instrReady;
  logic [31:0] rdData;

  dotacc_engine dut_i (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  string tag = "R1";

  logic [31:0] mAcc [ACC_N];
  logic [VEC_W-1:0] mRf [LANES][RF_D];
  typedef struct { int due; int row; bit clr; logic [LANES-1:0][31:0] res; } pend_t;
  pend_t pq[$];

  function automatic logic [31:0] dotf(logic [VEC_W-1:0] a, logic [VEC_W-1:0] b, bit f4);
    int s = 0;
    if (!f4) for (int i = 0; i < 64; i++) s += $signed(a[i*8 +: 8]) * $signed(b[i*8 +: 8]);
    else     for (int i = 0; i < 128; i++) s += $signed(a[i*4 +: 4]) * $signed(b[i*4 +: 4]);
    return s;
  endfunction

  function automatic logic [VEC_W-1:0] rndVec();
    logic [VEC_W-1:0] v;
    for (int i = 0; i < VEC_W/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ACC_N; i++) mAcc[i] = '0;
      pq.delete();
      cyc = 0;
    end else begin
      cyc++;
      while (pq.size() > 0 && pq[0].due == cyc) begin
        for (int l = 0; l < LANES; l++)
          mAcc[pq[0].row*LANES + l] = pq[0].clr ? pq[0].res[l] : mAcc[pq[0].row*LANES + l] + pq[0].res[l];
        void'(pq.pop_front());
      end
      if (instrValid && !(rfWrEn && instrSrcRf)) begin
        pend_t p;
        p.due = cyc + 3; p.row = instrAccRow; p.clr = instrClear;
        for (int l = 0; l < LANES; l++)
          p.res[l] = dotf(instrSrcRf ? mRf[l][instrRfAddr] : streamVec, streamVec, instrFmt);
        pq.push_back(p);
      end
      if (rfWrEn) mRf[rfWrBank][rfWrAddr] = rfWrData;
    end
  end

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      total++;
      if (rdData !== mAcc[rdIdx]) begin
        bad++;
        $display("FAIL %s idx=%0d actual=%h expected=%h", tag, rdIdx, rdData, mAcc[rdIdx]);
      end
      total++;
      if (instrReady !== !(rfWrEn && instrSrcRf)) begin
        bad++;
        $display("FAIL R8 instrReady actual=%b expected=%b", instrReady, !(rfWrEn && instrSrcRf));
      end
    end
  end

  task automatic idle(int n);
    instrValid = 0; rfWrEn = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(bit src, bit f4, int row, bit clr, logic [VEC_W-1:0] sv, int ridx);
    instrValid = 1; instrSrcRf = src; instrFmt = f4; instrAccRow = 7'(row);
    instrClear = clr; instrRfAddr = 4'($urandom % RF_D); streamVec = sv; rdIdx = 10'(ridx);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset contents
    tag = "R1";
    for (int i = 0; i < 48; i++) begin rdIdx = 10'((i * 23) % ACC_N); @(negedge clk); end
    // R8: fill all banks
    tag = "R8";
    for (int b = 0; b < LANES; b++)
      for (int a = 0; a < RF_D; a++) begin
        rfWrEn = 1; rfWrBank = 3'(b); rfWrAddr = 4'(a); rfWrData = rndVec();
        @(negedge clk);
      end
    idle(2);
    // R2: 8-bit elements from banks
    tag = "R2";
    for (int i = 0; i < 40; i++) issue(1, 0, $urandom % 4, ($urandom % 5) == 0, rndVec(), $urandom % 32);
    idle(4);
    // R3: 4-bit elements
    tag = "R3";
    for (int i = 0; i < 40; i++) issue(1, 1, $urandom % 4, ($urandom % 5) == 0, rndVec(), $urandom % 32);
    idle(4);
    // R4: stream-sourced operand A, both formats, wider row spread
    tag = "R4";
    for (int i = 0; i < 40; i++) issue(0, $urandom % 2, 8 + $urandom % 4, 0, rndVec(), 64 + $urandom % 32);
    idle(4);
    // R5: clear then repeated maximal sums until 32-bit wrap
    tag = "R5";
    issue(0, 0, 5, 1, {64{8'h80}}, 40);
    for (int i = 0; i < 2100; i++) issue(0, 0, 5, 0, {64{8'h80}}, 40 + (i % 8));
    idle(4);
    issue(0, 1, 5, 1, rndVec(), 41);
    idle(4);
    // R7: back-to-back to one row
    tag = "R7";
    for (int i = 0; i < 40; i++) issue($urandom % 2, $urandom % 2, 3, i == 0, rndVec(), 24 + (i % 8));
    idle(4);
    // R8: write during bank-sourced instructions stalls them; stream-sourced proceed
    tag = "R8";
    for (int i = 0; i < 12; i++) begin
      rfWrEn = 1; rfWrBank = 3'($urandom % LANES); rfWrAddr = 4'($urandom % RF_D); rfWrData = rndVec();
      issue(i % 3 != 0, 0, 2, 0, rndVec(), 16 + (i % 8));
    end
    rfWrEn = 0;
    for (int i = 0; i < 20; i++) issue(1, 0, 2, 0, rndVec(), 16 + (i % 8));
    idle(4);
    // R6: single instruction, watch its entry cycle by cycle
    tag = "R6";
    issue(1, 0, 7, 0, rndVec(), 56);
    idle(6);
    issue(0, 1, 7, 0, rndVec(), 63);
    idle(6);
    // R9: full sweep, untouched rows must still be zero
    tag = "R9";
    for (int i = 0; i < ACC_N; i++) begin rdIdx = 10'(i); @(negedge clk); end
    summary();
  end
endmodule